// File: doc/BRIEF.md
# Compact Branch Next-PC Unit

This block resolves the control-flow outcome of compact branches and register-indexed jumps, which have no delay slot. Each cycle it can accept one decoded instruction word. Along with the word it takes the current program counter and the two source register values that were already read for the instruction. One clock later it presents the next program counter and a redirect flag. When the instruction links, it also presents a write enable for register 31 and the link value.

Because there is no delay slot, the link value is always the address of the following word, PC + 4. A taken branch or a jump raises the redirect flag, so the fetch stage drops its sequential increment. One major opcode carries two forms, told apart by the 5-bit field in bits 25:21:
- a branch-if-zero with a scaled 21-bit offset, when that field is nonzero;
- a register-indexed jump, when that field is zero.

All address arithmetic is `XLEN` bits wide and wraps.

Top module: `cbr_next_pc`

## Requirements
- R1: While `rst_n` is low, and afterwards until the first cycle with `dec_valid` high, `out_valid`, `redirect`, `link_we`, `next_pc` and `link_val` are all zero.
- R2: In the cycle after one with `dec_valid` low, `out_valid`, `redirect` and `link_we` are 0, and `next_pc` and `link_val` are zero.
- R3: Opcode `instr[31:26]` = 6'h32 (compact branch): `next_pc` = pc + 4 + (sign-extended `instr[25:0]` << 2), `redirect` = 1, `link_we` = 0, `link_val` = 0.
- R4: Opcode 6'h3A (compact branch and link): same target as R3, `redirect` = 1, `link_we` = 1, `link_val` = pc + 4.
- R5: Opcode 6'h36 with `instr[25:21]` nonzero (branch if zero): if `rs_val` is zero, `next_pc` = pc + 4 + (sign-extended `instr[20:0]` << 2) and `redirect` = 1. Otherwise `next_pc` = pc + 4 and `redirect` = 0. `link_we` = 0 in both cases.
- R6: Opcode 6'h36 with `instr[25:21]` zero (indexed jump): `next_pc` = `rt_val` + sign-extended `instr[15:0]`, `redirect` = 1, `link_we` = 0.
- R7: Opcode 6'h3E with `instr[25:21]` zero (indexed jump and link): `next_pc` = `rt_val` + sign-extended `instr[15:0]`, `redirect` = 1, `link_we` = 1, `link_val` = pc + 4.
- R8: Any other opcode, and opcode 6'h3E with `instr[25:21]` nonzero, give `next_pc` = pc + 4, `redirect` = 0, `link_we` = 0 and `link_val` = 0.
- R9: All target and link sums are taken modulo 2^XLEN.
- R10: `out_valid` is high exactly in the cycle after a cycle with `dec_valid` high, and the other outputs in that cycle reflect the inputs of that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | Decoded instruction present this cycle |
| instr | input | 32 | Instruction word |
| pc | input | XLEN | Address of the instruction |
| rs_val | input | XLEN | Value read from the register named in bits 25:21 |
| rt_val | input | XLEN | Value read from the register named in bits 20:16 |
| out_valid | output | 1 | Result present |
| next_pc | output | XLEN | Address to fetch next |
| redirect | output | 1 | Fetch must go to `next_pc` instead of the sequential address |
| link_we | output | 1 | Write `link_val` to register 31 |
| link_val | output | XLEN | Return address |

## Verification
The bench builds the block with its default parameters: XLEN = 64 and the four default opcode values. At 64 bits, the wrap case of R9 can be reached with a PC of all ones minus three and with an `rt_val` near the top of the range. Both the most negative and the most positive 26-, 21- and 16-bit offsets also land on exact 64-bit values, which the model checks independently. The instruction stream is issued back to back and with idle gaps between words. This covers the one-cycle latency of R10 and the quiet outputs of R2.

// File: rtl/cbr_next_pc.sv
module cbr_next_pc #(
  parameter int XLEN = 64,
  parameter logic [5:0] OP_BC   = 6'h32,
  parameter logic [5:0] OP_BALC = 6'h3A,
  parameter logic [5:0] OP_BZJ  = 6'h36,
  parameter logic [5:0] OP_JIL  = 6'h3E
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dec_valid,
  input  logic [31:0]     instr,
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] rs_val,
  input  logic [XLEN-1:0] rt_val,
  output logic            out_valid,
  output logic [XLEN-1:0] next_pc,
  output logic            redirect,
  output logic            link_we,
  output logic [XLEN-1:0] link_val
);

  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  wire [5:0] opc     = instr[31:26];
  wire       rs_zero = (instr[25:21] == 5'd0);

  wire [XLEN-1:0] seq_pc = pc + STEP;
  wire [XLEN-1:0] off26  = {{(XLEN-28){instr[25]}}, instr[25:0], 2'b00};
  wire [XLEN-1:0] off21  = {{(XLEN-23){instr[20]}}, instr[20:0], 2'b00};
  wire [XLEN-1:0] imm16  = {{(XLEN-16){instr[15]}}, instr[15:0]};
  wire [XLEN-1:0] rel26  = seq_pc + off26;
  wire [XLEN-1:0] rel21  = seq_pc + off21;
  wire [XLEN-1:0] idx_tg = rt_val + imm16;

  logic [XLEN-1:0] c_next;
  logic            c_redir;
  logic            c_link;

  always_comb begin
    c_next  = seq_pc;
    c_redir = 1'b0;
    c_link  = 1'b0;
    if (opc == OP_BC) begin
      c_next  = rel26;
      c_redir = 1'b1;
    end else if (opc == OP_BALC) begin
      c_next  = rel26;
      c_redir = 1'b1;
      c_link  = 1'b1;
    end else if (opc == OP_BZJ) begin
      if (rs_zero) begin
        c_next  = idx_tg;
        c_redir = 1'b1;
      end else if (rs_val == '0) begin
        c_next  = rel21;
        c_redir = 1'b1;
      end
    end else if (opc == OP_JIL && rs_zero) begin
      c_next  = idx_tg;
      c_redir = 1'b1;
      c_link  = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !dec_valid) begin
      out_valid <= 1'b0;
      next_pc   <= '0;
      redirect  <= 1'b0;
      link_we   <= 1'b0;
      link_val  <= '0;
    end else begin
      out_valid <= 1'b1;
      next_pc   <= c_next;
      redirect  <= c_redir;
      link_we   <= c_link;
      link_val  <= c_link ? seq_pc : '0;
    end
  end

  logic armed;
  always_ff @(posedge clk) armed <= rst_n;

  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!redirect && !link_we && next_pc == '0 && link_val == '0)); // R2
  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (out_valid == $past(dec_valid))); // R10
  AST_SEQ_FALLTHRU: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && out_valid && !redirect) |-> (next_pc == $past(pc) + STEP)); // R8
  AST_LINK_RET: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && link_we) |-> (link_val == $past(pc) + STEP && redirect)); // R7
  AST_BC_NOLINK: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && out_valid && $past(instr[31:26]) == OP_BC) |-> (redirect && !link_we)); // R3
  AST_BALC_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && out_valid && $past(instr[31:26]) == OP_BALC) |-> (redirect && link_we)); // R4

endmodule

// File: tb/tb_cbr_next_pc.sv
module tb_cbr_next_pc;
  localparam int XLEN = 64;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            dec_valid = 1'b0;
  logic [31:0]     instr = '0;
  logic [XLEN-1:0] pc = '0, rs_val = '0, rt_val = '0;
  logic            out_valid, redirect, link_we;
  logic [XLEN-1:0] next_pc, link_val;

  always #4 clk = ~clk;

  cbr_next_pc dut (
    .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .instr(instr),
    .pc(pc), .rs_val(rs_val), .rt_val(rt_val), .out_valid(out_valid),
    .next_pc(next_pc), .redirect(redirect), .link_we(link_we), .link_val(link_val)
  );

  typedef struct {
    logic [63:0] npc;
    logic        rd;
    logic        lw;
    logic [63:0] lv;
    string       tag;
  } exp_t;

  exp_t q[$];
  int total = 0;
  int bad = 0;
  bit done = 0;

  function automatic exp_t model(input logic [31:0] w, input logic [63:0] p,
                                 input logic [63:0] rs, input logic [63:0] rt,
                                 input string tag);
    exp_t e;
    logic [63:0] s26, s21, s16;
    s26 = {{38{w[25]}}, w[25:0]};
    s21 = {{43{w[20]}}, w[20:0]};
    s16 = {{48{w[15]}}, w[15:0]};
    e.npc = p + 64'd4; e.rd = 0; e.lw = 0; e.lv = 0; e.tag = tag;
    case (w[31:26])
      6'h32: begin e.npc = p + 64'd4 + s26 * 64'd4; e.rd = 1; end
      6'h3A: begin e.npc = p + 64'd4 + s26 * 64'd4; e.rd = 1; e.lw = 1; e.lv = p + 64'd4; end
      6'h36: if (w[25:21] == 0) begin e.npc = rt + s16; e.rd = 1; end
             else if (rs == 0) begin e.npc = p + 64'd4 + s21 * 64'd4; e.rd = 1; end
      6'h3E: if (w[25:21] == 0) begin e.npc = rt + s16; e.rd = 1; e.lw = 1; e.lv = p + 64'd4; end
      default: ;
    endcase
    return e;
  endfunction

  task automatic issue(input logic [31:0] w, input logic [63:0] p,
                       input logic [63:0] rs, input logic [63:0] rt, input string tag);
    @(negedge clk);
    dec_valid = 1; instr = w; pc = p; rs_val = rs; rt_val = rt;
    q.push_back(model(w, p, rs, rt, tag));
  endtask

  task automatic idle(input logic [31:0] w);
    @(negedge clk);
    dec_valid = 0; instr = w; pc = 64'hDEAD_BEEF_0000_1000; rt_val = 64'h1234;
  endtask

  always @(posedge clk) begin
    if (rst_n) begin
      #2;
      if (out_valid) begin
        total++;
        if (q.size() == 0) begin
          bad++; $display("FAIL R10 unexpected result actual out_valid=1 expected 0");
        end else begin
          exp_t e;
          e = q.pop_front();
          if (next_pc !== e.npc || redirect !== e.rd || link_we !== e.lw || link_val !== e.lv) begin
            bad++;
            $display("FAIL %s actual npc=%h rd=%b lw=%b lv=%h expected npc=%h rd=%b lw=%b lv=%h",
                     e.tag, next_pc, redirect, link_we, link_val, e.npc, e.rd, e.lw, e.lv);
          end
        end
      end else begin
        total++;
        if (q.size() != 0) begin
          bad++; $display("FAIL R10 missing result actual out_valid=0 expected 1");
          void'(q.pop_front());
        end else if (redirect !== 0 || link_we !== 0 || next_pc !== 0 || link_val !== 0) begin
          bad++;
          $display("FAIL R2 idle outputs actual rd=%b lw=%b npc=%h lv=%h expected all zero",
                   redirect, link_we, next_pc, link_val);
        end
      end
    end
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual hung expected finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    dec_valid = 1; instr = {6'h32, 26'h1};
    repeat (3) @(negedge clk);
    total++;
    if (out_valid !== 0 || redirect !== 0 || link_we !== 0 || next_pc !== 0 || link_val !== 0) begin
      bad++;
      $display("FAIL R1 reset actual ov=%b rd=%b lw=%b npc=%h lv=%h expected all zero",
               out_valid, redirect, link_we, next_pc, link_val);
    end
    dec_valid = 0;
    @(negedge clk);
    rst_n = 1;
    idle({6'h3A, 26'h5});
    idle({6'h32, 26'h7});
    // R3 compact branch, forward, backward, extremes
    issue({6'h32, 26'h0000010}, 64'h0000_0000_0040_0000, 0, 0, "R3 fwd");
    issue({6'h32, 26'h3FFFFFF}, 64'h0000_0000_0040_0000, 0, 0, "R3 back");
    issue({6'h32, 26'h2000000}, 64'h0000_0001_0000_0000, 0, 0, "R3 most negative");
    issue({6'h32, 26'h1FFFFFF}, 64'h0000_0000_0000_1000, 0, 0, "R3 most positive");
    // R4 branch and link
    issue({6'h3A, 26'h0000100}, 64'h0000_0000_1000_0000, 0, 0, "R4 link fwd");
    issue({6'h3A, 26'h3FFFF00}, 64'h0000_0000_1000_0000, 0, 0, "R4 link back");
    idle(0);
    // R5 branch if zero
    issue({6'h36, 5'd3, 21'h000040}, 64'h0000_0000_0000_2000, 0, 64'h55, "R5 taken");
    issue({6'h36, 5'd3, 21'h000040}, 64'h0000_0000_0000_2000, 1, 64'h55, "R5 not taken");
    issue({6'h36, 5'd31, 21'h100000}, 64'h0000_0000_8000_0000, 0, 0, "R5 most negative");
    issue({6'h36, 5'd1, 21'h0FFFFF}, 64'h0, 0, 0, "R5 most positive");
    issue({6'h36, 5'd1, 21'h1FFFFF}, 64'h100, 64'h8000_0000_0000_0000, 0, "R5 sign rs nonzero");
    // R6 indexed jump
    issue({6'h36, 5'd0, 5'd4, 16'h0010}, 64'h300, 64'h9, 64'h0000_0000_0000_4000, "R6 pos");
    issue({6'h36, 5'd0, 5'd4, 16'h8000}, 64'h300, 0, 64'h0000_0000_0001_0000, "R6 neg");
    // R7 indexed jump and link
    issue({6'h3E, 5'd0, 5'd7, 16'hFFFC}, 64'h0000_0000_0000_0800, 0, 64'h0000_0000_0010_0000, "R7 link");
    issue({6'h3E, 5'd0, 5'd7, 16'h7FFF}, 64'h0000_0000_0000_0804, 0, 64'h20, "R7 link pos");
    idle({6'h3E, 26'h0});
    // R8 unrecognised
    issue({6'h3E, 5'd2, 21'h12345}, 64'h0000_0000_0000_0900, 0, 64'h77, "R8 jil rs nonzero");
    issue({6'h00, 26'h3FFFFFF}, 64'h0000_0000_0000_0A00, 0, 0, "R8 other opcode");
    issue({6'h33, 26'h0000010}, 64'h0000_0000_0000_0B00, 0, 0, "R8 near opcode");
    // R9 wrap
    issue({6'h32, 26'h0}, 64'hFFFF_FFFF_FFFF_FFFC, 0, 0, "R9 bc wrap");
    issue({6'h3A, 26'h1}, 64'hFFFF_FFFF_FFFF_FFFC, 0, 0, "R9 balc wrap");
    issue({6'h36, 5'd0, 5'd1, 16'h0010}, 64'h0, 0, 64'hFFFF_FFFF_FFFF_FFF8, "R9 jump wrap");
    issue({6'h32, 26'h3FFFFFE}, 64'h0, 0, 0, "R9 underflow");
    // R10 gaps
    idle(0);
    issue({6'h32, 26'h4}, 64'h40, 0, 0, "R10 after gap");
    idle(0);
    idle(0);
    @(negedge clk); dec_valid = 0;
    repeat (3) @(negedge clk);
    total++;
    if (q.size() != 0) begin
      bad++; $display("FAIL R10 leftover actual %0d expected 0", q.size());
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule